// File: doc/BRIEF.md
# Timer Array Control and Status

This block holds the register-facing control state for an array of timer channels (four by default). Software reaches it through a single-cycle write port (valid, address, data) and a combinational read port (address in, data out). It keeps a per-channel interrupt mask, a per-channel sticky timeout flag, a per-channel enable, and a small module control register. The enable is written through two separate addresses: one sets enable bits and the other clears them.

The channel counters sit outside this block. Each counter sends a one-cycle timeout pulse in and gets back an enable and a run permit. The run permit drops while the debug or doze input is active, unless the matching control bit allows the channel to keep running. A combined interrupt output is raised whenever a flag and its mask bit are both set. Setting the software reset bit has these effects:

- Every other register is held cleared.
- Timeouts are ignored.
- A reset strobe goes to the channels.
- The control register itself keeps its contents.

Top module: `tmr_array_ctrl`

## Requirements
- R1: After the reset input is released, every address reads zero, and irqOut, chanEnable, chanRunPermit and chanSoftReset are all low. This means both run-in bits default to halt.
- R2: A write to address 1 loads the interrupt mask from the low data bits, with channel n at bit n. The mask reads back at address 1 from the next cycle on.
- R3: A timeout pulse on channel n sets flag bit n, which reads at address 2 from the cycle after the pulse. The flag stays set until it is cleared.
- R4: A write to address 2 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: When a timeout and a clear of the same flag land in the same cycle, the flag ends up set.
- R6: irqOut is high exactly when at least one channel has both its flag and its mask bit set.
- R7: A write to address 3 sets each enable bit whose data bit is 1, and zero bits have no effect. The enables drive chanEnable and read back at address 3.
- R8: A write to address 4 clears each enable bit whose data bit is 1, and zero bits have no effect. Clear takes priority over set within the update.
- R9: The control register at address 0 holds the software reset bit at bit 0, run-in-debug at bit 1 and run-in-doze at bit 2. chanRunPermit[n] is chanEnable[n], forced low while debugActive is high and bit 1 is 0, and forced low while dozeActive is high and bit 2 is 0.
- R10: While control bit 0 is 1, the following hold:
  - Flags, mask and enables are cleared from the next edge on, and timeouts are ignored.
  - chanSoftReset is high and chanRunPermit is low.
  - The control register keeps its value.
- R11: Reads of address 4 and of any address above 4 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | ADDR_W (3) | Write register address |
| wrData | input | DATA_W (32) | Write data |
| rdAddr | input | ADDR_W (3) | Read register address |
| rdData | output | DATA_W (32) | Read data, combinational from rdAddr |
| timeoutPulse | input | N_CHAN (4) | Per-channel timeout pulses from the counters |
| debugActive | input | 1 | Debug halt request |
| dozeActive | input | 1 | Doze halt request |
| chanEnable | output | N_CHAN (4) | Per-channel enable state |
| chanRunPermit | output | N_CHAN (4) | Per-channel permission to count this cycle |
| chanSoftReset | output | 1 | Software reset strobe to the channels |
| irqOut | output | 1 | Combined interrupt |

## Verification
Two situations are the hardest to reach from the ports.

The first is a timeout pulse arriving in the same cycle as a write-one-to-clear of the same flag. The stimulus table drives both in one vector, then reads the status back.

The second is the software reset window. The bench fills the mask, flags and enables, writes the reset bit, and pulses timeouts while the bit is held. It then releases the bit through a control write and checks that every register except control reads zero and that the reset strobe falls.

// File: rtl/tmr_array_pkg.sv
package tmr_array_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_MASK   = 3'd1,
    ADDR_STATUS = 3'd2,
    ADDR_SETEN  = 3'd3,
    ADDR_CLREN  = 3'd4
  } regAddr_e;

  localparam int CTRL_W      = 3;
  localparam int CTRL_SWRST  = 0;
  localparam int CTRL_RUNDBG = 1;
  localparam int CTRL_RUNDOZ = 2;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic clrFlags;
    logic setEn;
    logic clrEn;
  } regStrobe_t;

endpackage

// File: rtl/tmr_array_decode.sv
module tmr_array_decode
  import tmr_array_pkg::*;
(
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    if (wrValid) begin
      unique case (wrAddr)
        ADDR_CTRL:   strobe.wrCtrl   = 1'b1;
        ADDR_MASK:   strobe.wrMask   = 1'b1;
        ADDR_STATUS: strobe.clrFlags = 1'b1;
        ADDR_SETEN:  strobe.setEn    = 1'b1;
        ADDR_CLREN:  strobe.clrEn    = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_array_regs.sv
module tmr_array_regs
  import tmr_array_pkg::*;
#(
  parameter int N_CHAN = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_CHAN-1:0] timeoutPulse,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [N_CHAN-1:0] maskReg,
  output logic [N_CHAN-1:0] flagReg,
  output logic [N_CHAN-1:0] enReg
);

  logic              swRst;
  logic [N_CHAN-1:0] chanBits;
  logic [N_CHAN-1:0] flagClr;
  logic [N_CHAN-1:0] enSet;
  logic [N_CHAN-1:0] enClr;

  assign swRst    = ctrlReg[CTRL_SWRST];
  assign chanBits = wrData[N_CHAN-1:0];
  assign flagClr  = strobe.clrFlags ? chanBits : '0;
  assign enSet    = strobe.setEn    ? chanBits : '0;
  assign enClr    = strobe.clrEn    ? chanBits : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strobe.wrCtrl) begin
      ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
    end else if (swRst) begin
      maskReg <= '0;
    end else if (strobe.wrMask) begin
      maskReg <= chanBits;
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < N_CHAN; ch++) begin : g_chan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagReg[ch] <= 1'b0;
          enReg[ch]   <= 1'b0;
        end else if (swRst) begin
          flagReg[ch] <= 1'b0;
          enReg[ch]   <= 1'b0;
        end else begin
          flagReg[ch] <= timeoutPulse[ch] | (flagReg[ch] & ~flagClr[ch]);
          enReg[ch]   <= (enReg[ch] | enSet[ch]) & ~enClr[ch];
        end
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL:   rdData[CTRL_W-1:0] = ctrlReg;
      ADDR_MASK:   rdData[N_CHAN-1:0] = maskReg;
      ADDR_STATUS: rdData[N_CHAN-1:0] = flagReg;
      ADDR_SETEN:  rdData[N_CHAN-1:0] = enReg;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_array_ctrl.sv
module tmr_array_ctrl
  import tmr_array_pkg::*;
#(
  parameter int N_CHAN = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [N_CHAN-1:0] timeoutPulse,
  input  logic              debugActive,
  input  logic              dozeActive,
  output logic [N_CHAN-1:0] chanEnable,
  output logic [N_CHAN-1:0] chanRunPermit,
  output logic              chanSoftReset,
  output logic              irqOut
);

  regStrobe_t        strobe;
  logic [CTRL_W-1:0] ctrlReg;
  logic [N_CHAN-1:0] maskReg;
  logic [N_CHAN-1:0] flagReg;
  logic [N_CHAN-1:0] enReg;
  logic              haltAll;

  tmr_array_decode i_decode (
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .strobe  (strobe)
  );

  tmr_array_regs #(
    .N_CHAN (N_CHAN),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .timeoutPulse (timeoutPulse),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .ctrlReg      (ctrlReg),
    .maskReg      (maskReg),
    .flagReg      (flagReg),
    .enReg        (enReg)
  );

  assign haltAll = ctrlReg[CTRL_SWRST]
                 | (debugActive & ~ctrlReg[CTRL_RUNDBG])
                 | (dozeActive  & ~ctrlReg[CTRL_RUNDOZ]);

  assign chanEnable    = enReg;
  assign chanRunPermit = haltAll ? '0 : enReg;
  assign chanSoftReset = ctrlReg[CTRL_SWRST];
  assign irqOut        = |(flagReg & maskReg);

endmodule

// File: rtl/tmr_array_ctrl_chk.sv
module tmr_array_ctrl_chk
  import tmr_array_pkg::*;
#(
  parameter int N_CHAN = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [N_CHAN-1:0] timeoutPulse,
  input logic              debugActive,
  input logic [CTRL_W-1:0] ctrlReg,
  input logic [N_CHAN-1:0] maskReg,
  input logic [N_CHAN-1:0] flagReg,
  input logic [N_CHAN-1:0] enReg,
  input logic [N_CHAN-1:0] chanRunPermit,
  input logic              irqOut
);

  genvar ch;
  generate
    for (ch = 0; ch < N_CHAN; ch++) begin : g_chk
      AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rstN)
        (timeoutPulse[ch] && !ctrlReg[CTRL_SWRST]) |=> flagReg[ch]); // R3
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (flagReg[ch] && !ctrlReg[CTRL_SWRST]
         && !(wrValid && wrAddr == ADDR_STATUS && wrData[ch])) |=> flagReg[ch]); // R4
      AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
        (wrValid && wrAddr == ADDR_CLREN && wrData[ch]) |=> !enReg[ch]); // R8
    end
  endgenerate

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (flagReg != '0 && maskReg != '0)); // R6
  AST_DEBUG_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (debugActive && !ctrlReg[CTRL_RUNDBG]) |-> chanRunPermit == '0); // R9
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[CTRL_SWRST] |=> (flagReg == '0 && maskReg == '0 && enReg == '0)); // R10

endmodule

bind tmr_array_ctrl tmr_array_ctrl_chk #(
  .N_CHAN (N_CHAN),
  .DATA_W (DATA_W)
) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .wrValid       (wrValid),
  .wrAddr        (wrAddr),
  .wrData        (wrData),
  .timeoutPulse  (timeoutPulse),
  .debugActive   (debugActive),
  .ctrlReg       (ctrlReg),
  .maskReg       (maskReg),
  .flagReg       (flagReg),
  .enReg         (enReg),
  .chanRunPermit (chanRunPermit),
  .irqOut        (irqOut)
);

// File: tb/test_tmr_array_ctrl.sv
module test_tmr_array_ctrl;

  localparam int N_CHAN = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int N_VEC  = 14;

  typedef struct packed {
    logic [3:0]        req;
    logic              wrV;
    logic [ADDR_W-1:0] wrA;
    logic [DATA_W-1:0] wrD;
    logic [N_CHAN-1:0] tmo;
    logic [ADDR_W-1:0] rdA;
    logic [DATA_W-1:0] expRd;
    logic              expIrq;
    logic [N_CHAN-1:0] expEn;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{4'd2,  1'b1, 3'd1, 32'h5, 4'h0, 3'd1, 32'h5, 1'b0, 4'h0}, // R2 mask write
    '{4'd3,  1'b0, 3'd0, 32'h0, 4'h3, 3'd2, 32'h3, 1'b1, 4'h0}, // R3 timeouts 0,1; R6 irq via ch0
    '{4'd4,  1'b1, 3'd2, 32'h1, 4'h0, 3'd2, 32'h2, 1'b0, 4'h0}, // R4 clear ch0 only
    '{4'd4,  1'b1, 3'd2, 32'h0, 4'h0, 3'd2, 32'h2, 1'b0, 4'h0}, // R4 zero write no effect
    '{4'd6,  1'b1, 3'd1, 32'h2, 4'h0, 3'd2, 32'h2, 1'b1, 4'h0}, // R6 mask ch1 raises irq
    '{4'd5,  1'b1, 3'd2, 32'h2, 4'h2, 3'd2, 32'h2, 1'b1, 4'h0}, // R5 timeout beats clear
    '{4'd4,  1'b1, 3'd2, 32'hF, 4'h0, 3'd2, 32'h0, 1'b0, 4'h0}, // R4 clear all
    '{4'd3,  1'b0, 3'd0, 32'h0, 4'h8, 3'd2, 32'h8, 1'b0, 4'h0}, // R3 ch3, R6 unmasked no irq
    '{4'd7,  1'b1, 3'd3, 32'h9, 4'h0, 3'd3, 32'h9, 1'b0, 4'h9}, // R7 set enables
    '{4'd7,  1'b1, 3'd3, 32'h0, 4'h0, 3'd3, 32'h9, 1'b0, 4'h9}, // R7 zero set no effect
    '{4'd8,  1'b1, 3'd4, 32'h1, 4'h0, 3'd3, 32'h8, 1'b0, 4'h8}, // R8 clear ch0
    '{4'd8,  1'b1, 3'd4, 32'h0, 4'h0, 3'd4, 32'h0, 1'b0, 4'h8}, // R8 zero clear; R11 read addr 4
    '{4'd9,  1'b1, 3'd0, 32'h6, 4'h0, 3'd0, 32'h6, 1'b0, 4'h8}, // R9 control run bits
    '{4'd11, 1'b0, 3'd0, 32'h0, 4'h0, 3'd7, 32'h0, 1'b0, 4'h8}  // R11 unmapped read
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic [N_CHAN-1:0] timeoutPulse = '0;
  logic              debugActive = 1'b0;
  logic              dozeActive = 1'b0;
  logic [N_CHAN-1:0] chanEnable;
  logic [N_CHAN-1:0] chanRunPermit;
  logic              chanSoftReset;
  logic              irqOut;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tmr_array_ctrl #(.N_CHAN(N_CHAN), .DATA_W(DATA_W)) i_tmr_array_ctrl (
    .clk (clk), .rstN (rstN), .wrValid (wrValid), .wrAddr (wrAddr),
    .wrData (wrData), .rdAddr (rdAddr), .rdData (rdData),
    .timeoutPulse (timeoutPulse), .debugActive (debugActive),
    .dozeActive (dozeActive), .chanEnable (chanEnable),
    .chanRunPermit (chanRunPermit), .chanSoftReset (chanSoftReset),
    .irqOut (irqOut)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, let one edge capture them, then idle inputs
  task automatic step(input logic v, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [N_CHAN-1:0] t);
    @(negedge clk);
    wrValid = v; wrAddr = a; wrData = d; timeoutPulse = t;
    @(negedge clk);
    wrValid = 1'b0; wrData = '0; timeoutPulse = '0;
  endtask

  task automatic readCheck(input string tag, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] exp);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) readCheck("R1 reset read", a[ADDR_W-1:0], '0);
    check("R1 irqOut", {31'b0, irqOut}, '0);
    check("R1 chanEnable", {28'b0, chanEnable}, '0);
    check("R1 chanRunPermit", {28'b0, chanRunPermit}, '0);
    check("R1 chanSoftReset", {31'b0, chanSoftReset}, '0);

    for (int i = 0; i < N_VEC; i++) begin
      step(VECS[i].wrV, VECS[i].wrA, VECS[i].wrD, VECS[i].tmo);
      readCheck($sformatf("R%0d vector %0d rdData", VECS[i].req, i),
                VECS[i].rdA, VECS[i].expRd);
      check($sformatf("R%0d vector %0d irqOut", VECS[i].req, i),
            {31'b0, irqOut}, {31'b0, VECS[i].expIrq});
      check($sformatf("R%0d vector %0d chanEnable", VECS[i].req, i),
            {28'b0, chanEnable}, {28'b0, VECS[i].expEn});
    end

    // R9 run permit; control = 6 (both run bits), enable = 8
    check("R9 permit running", {28'b0, chanRunPermit}, 32'h8);
    debugActive = 1'b1; dozeActive = 1'b1; #1;
    check("R9 permit allowed in dbg+doze", {28'b0, chanRunPermit}, 32'h8);
    step(1'b1, 3'd0, 32'h2, 4'h0); // run in debug only
    check("R9 doze halts", {28'b0, chanRunPermit}, 32'h0);
    dozeActive = 1'b0; #1;
    check("R9 debug allowed", {28'b0, chanRunPermit}, 32'h8);
    step(1'b1, 3'd0, 32'h0, 4'h0);
    check("R9 debug halts", {28'b0, chanRunPermit}, 32'h0);
    debugActive = 1'b0; dozeActive = 1'b1; #1;
    check("R9 doze halts default", {28'b0, chanRunPermit}, 32'h0);
    dozeActive = 1'b0; #1;
    check("R9 no halt request", {28'b0, chanRunPermit}, 32'h8);

    // R10 software reset
    step(1'b1, 3'd1, 32'hF, 4'hF);
    step(1'b1, 3'd3, 32'h7, 4'h0);
    check("R10 irq before reset", {31'b0, irqOut}, 32'h1);
    step(1'b1, 3'd0, 32'h3, 4'h0);
    check("R10 chanSoftReset high", {31'b0, chanSoftReset}, 32'h1);
    check("R10 permit low in reset", {28'b0, chanRunPermit}, 32'h0);
    step(1'b0, 3'd0, 32'h0, 4'hF); // timeouts during reset
    readCheck("R10 status cleared", 3'd2, 32'h0);
    readCheck("R10 mask cleared", 3'd1, 32'h0);
    readCheck("R10 enables cleared", 3'd3, 32'h0);
    readCheck("R10 control kept", 3'd0, 32'h3);
    check("R10 irq low", {31'b0, irqOut}, 32'h0);
    step(1'b1, 3'd0, 32'h2, 4'h0); // release
    check("R10 chanSoftReset released", {31'b0, chanSoftReset}, 32'h0);
    readCheck("R10 status after release", 3'd2, 32'h0);
    readCheck("R10 control after release", 3'd0, 32'h2);
    step(1'b0, 3'd0, 32'h0, 4'h4);
    readCheck("R3 timeout after release", 3'd2, 32'h4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule